// File: doc/BRIEF.md
# Transmit Mailbox Priority Scheduler

This block decides which of a small set of transmit mailboxes a CAN controller puts on the bus next. Software-side logic loads a mailbox with an identifier, which raises its request. The scheduler offers one pending mailbox to the transmit engine through a valid flag, an index and the identifier. The engine starts an attempt, and later returns one result: success, lost arbitration or error.

Two configuration inputs shape the policy. The first picks the ordering. In identifier order the lowest identifier goes first. In arrival order the mailbox whose request is oldest goes first. The second input disables automatic retransmission. A failed attempt then ends the request and is reported as a failure, instead of leaving the mailbox pending for another try. Each request ends with a one-cycle completion report that carries the mailbox index and a success flag.

Top module: `txmb_sched`

## Requirements
- R1: After reset no mailbox is pending, `sel_valid` is 0 and `done_valid` is 0.
- R2: A load is taken only into a mailbox that is not pending. A load aimed at a pending mailbox is ignored and leaves its identifier unchanged.
- R3: With `cfg_fifo_order`=0, the pending mailbox with the numerically lowest identifier is offered.
- R4: In identifier order, when pending identifiers are equal, the lower mailbox index is offered.
- R5: With `cfg_fifo_order`=1, pending mailboxes are offered in the order their loads were accepted, whatever their identifiers, and the order is kept as mailboxes complete.
- R6: From the cycle after `att_start` is accepted until the cycle after `att_done`, `sel_valid` stays 1 and `sel_idx`/`sel_id` stay fixed, even if a mailbox that would otherwise win is loaded.
- R7: `att_result`=0 (success) ends the attempt. In the next cycle `done_valid`=1, `done_ok`=1 and `done_idx` is the attempted mailbox, and that mailbox is free to be loaded again.
- R8: With `cfg_no_retry`=0, `att_result`=1 (arbitration lost) or 2 (error) produces no completion and leaves the mailbox pending, so that it is offered again.
- R9: With `cfg_no_retry`=1, a failed result produces `done_valid`=1 with `done_ok`=0 in the next cycle and frees the mailbox.
- R10: `att_start` with nothing pending, and `att_done` with no attempt running, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo_order | input | 1 | 1: arrival order, 0: lowest identifier first |
| cfg_no_retry | input | 1 | 1: a failed attempt ends the request |
| load_valid | input | 1 | Load request into mailbox `load_idx` |
| load_idx | input | 2 | Mailbox to load |
| load_id | input | 11 | Identifier for the loaded mailbox |
| sel_valid | output | 1 | A mailbox is offered |
| sel_idx | output | 2 | Offered mailbox index |
| sel_id | output | 11 | Identifier of the offered mailbox |
| att_start | input | 1 | Engine starts an attempt on the offered mailbox |
| att_done | input | 1 | Engine reports the attempt result |
| att_result | input | 2 | 0 success, 1 arbitration lost, 2 error, 3 treated as error |
| done_valid | output | 1 | One-cycle completion report |
| done_idx | output | 2 | Completed mailbox |
| done_ok | output | 1 | 1 success, 0 failure |

## Verification
The selection is driven by a table of three-mailbox fills. Each fill sets the load order, the identifiers and the ordering mode. Distinct identifiers separate lowest-first from index order. Equal identifiers expose the tie rule. Fills whose arrival order goes against identifier order separate the two modes. Directed sequences follow. One loads a better mailbox during an attempt. Others try every result code with and without retransmission. Another completes the head in arrival order and then reloads it, which shows that age order is kept across retirement.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
  typedef enum logic [1:0] {
    RES_OK  = 2'd0,
    RES_ARB = 2'd1,
    RES_ERR = 2'd2,
    RES_RSV = 2'd3
  } att_res_e;

  function automatic logic res_is_ok(input logic [1:0] code);
    return code == RES_OK;
  endfunction
endpackage

// File: rtl/txmb_slot.sv
module txmb_slot #(
  parameter int ID_W   = 11,
  parameter int RANK_W = 2,
  parameter int NUM_MB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ID_W-1:0]   load_id,
  input  logic [RANK_W-1:0] load_rank,
  input  logic              clr,
  input  logic              dec,
  output logic              pend,
  output logic [ID_W-1:0]   id,
  output logic [RANK_W-1:0] rank
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      id   <= '0;
      rank <= '0;
    end else if (clr) begin
      pend <= 1'b0;
    end else if (load) begin
      pend <= 1'b1;
      id   <= load_id;
      rank <= load_rank;
    end else if (dec) begin
      rank <= rank - 1'b1;
    end
  end

  AST_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !pend); // R2
  AST_RANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (32'(rank) < NUM_MB)); // R5
  AST_DEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (pend && rank != '0)); // R5
endmodule

// File: rtl/txmb_pick.sv
module txmb_pick #(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 11,
  parameter int RANK_W = 2,
  parameter int IDX_W  = 2
) (
  input  logic              fifo_mode,
  input  logic [NUM_MB-1:0] pend,
  input  logic [ID_W-1:0]   ids   [NUM_MB],
  input  logic [RANK_W-1:0] ranks [NUM_MB],
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  localparam int KEY_W = (ID_W > RANK_W) ? ID_W : RANK_W;

  function automatic logic [KEY_W-1:0] sort_key(input logic f,
                                                input logic [ID_W-1:0] i,
                                                input logic [RANK_W-1:0] r);
    return f ? KEY_W'(r) : KEY_W'(i);
  endfunction

  logic [KEY_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (pend[i] && (!found || sort_key(fifo_mode, ids[i], ranks[i]) < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = sort_key(fifo_mode, ids[i], ranks[i]);
      end
    end
  end
endmodule

// File: rtl/txmb_sched.sv
module txmb_sched #(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_fifo_order,
  input  logic                       cfg_no_retry,
  input  logic                       load_valid,
  input  logic [$clog2(NUM_MB)-1:0]  load_idx,
  input  logic [ID_W-1:0]            load_id,
  output logic                       sel_valid,
  output logic [$clog2(NUM_MB)-1:0]  sel_idx,
  output logic [ID_W-1:0]            sel_id,
  input  logic                       att_start,
  input  logic                       att_done,
  input  logic [1:0]                 att_result,
  output logic                       done_valid,
  output logic [$clog2(NUM_MB)-1:0]  done_idx,
  output logic                       done_ok
);
  import txmb_pkg::*;

  localparam int IDX_W  = $clog2(NUM_MB);
  localparam int RANK_W = IDX_W;

  function automatic logic [RANK_W-1:0] count_set(input logic [NUM_MB-1:0] v);
    logic [RANK_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_MB; i++) n = n + RANK_W'(v[i]);
    return n;
  endfunction

  logic [NUM_MB-1:0] pend, load_vec, clr_vec, dec_vec;
  logic [ID_W-1:0]   ids   [NUM_MB];
  logic [RANK_W-1:0] ranks [NUM_MB];
  logic              pick_found;
  logic [IDX_W-1:0]  pick_idx;
  logic              busy_q;
  logic [IDX_W-1:0]  cur_q;

  // named events for the assertions
  logic              accept, finish, retire;
  logic [RANK_W-1:0] retire_rank, new_rank;

  assign accept      = att_start && !busy_q && pick_found;
  assign finish      = att_done && busy_q;
  assign retire      = finish && (res_is_ok(att_result) || cfg_no_retry);
  assign retire_rank = ranks[cur_q];
  assign new_rank    = count_set(pend & ~clr_vec);

  generate
    for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
      assign load_vec[g] = load_valid && (load_idx == IDX_W'(g)) && !pend[g];
      assign clr_vec[g]  = retire && (cur_q == IDX_W'(g));
      assign dec_vec[g]  = retire && pend[g] && !clr_vec[g] && (ranks[g] > retire_rank);

      txmb_slot #(.ID_W(ID_W), .RANK_W(RANK_W), .NUM_MB(NUM_MB)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_vec[g]),
        .load_id  (load_id),
        .load_rank(new_rank),
        .clr      (clr_vec[g]),
        .dec      (dec_vec[g]),
        .pend     (pend[g]),
        .id       (ids[g]),
        .rank     (ranks[g])
      );
    end
  endgenerate

  txmb_pick #(.NUM_MB(NUM_MB), .ID_W(ID_W), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_pick (
    .fifo_mode(cfg_fifo_order),
    .pend     (pend),
    .ids      (ids),
    .ranks    (ranks),
    .found    (pick_found),
    .idx      (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cur_q      <= '0;
      done_valid <= 1'b0;
      done_idx   <= '0;
      done_ok    <= 1'b0;
    end else begin
      done_valid <= retire;
      if (retire) begin
        done_idx <= cur_q;
        done_ok  <= res_is_ok(att_result);
      end
      if (accept) begin
        busy_q <= 1'b1;
        cur_q  <= pick_idx;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign sel_valid = busy_q || pick_found;
  assign sel_idx   = busy_q ? cur_q : pick_idx;
  assign sel_id    = ids[sel_idx];

  AST_HOLD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !att_done) |=> (sel_valid && $stable(sel_idx) && $stable(sel_id))); // R6
  AST_OK_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && att_done && att_result == RES_OK) |=> (done_valid && done_ok)); // R7
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !pend[done_idx]); // R7
  AST_RETRY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && att_done && att_result != RES_OK && !cfg_no_retry) |=> (!done_valid && pend[$past(cur_q)])); // R8
  AST_NORETRY_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && att_done && cfg_no_retry) |=> done_valid); // R9
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> !done_valid); // R10
  AST_OFFER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> pend[sel_idx]); // R3
endmodule

// File: tb/txmb_sched_tb.sv
module txmb_sched_tb;
  localparam int NUM_MB = 3;
  localparam int ID_W   = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_fifo_order = 1'b0, cfg_no_retry = 1'b0;
  logic load_valid = 1'b0;
  logic [1:0] load_idx = '0;
  logic [ID_W-1:0] load_id = '0;
  logic sel_valid, done_valid, done_ok;
  logic [1:0] sel_idx, done_idx;
  logic [ID_W-1:0] sel_id;
  logic att_start = 1'b0, att_done = 1'b0;
  logic [1:0] att_result = '0;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  txmb_sched #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fifo_order(cfg_fifo_order), .cfg_no_retry(cfg_no_retry),
    .load_valid(load_valid), .load_idx(load_idx), .load_id(load_id),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_id(sel_id),
    .att_start(att_start), .att_done(att_done), .att_result(att_result),
    .done_valid(done_valid), .done_idx(done_idx), .done_ok(done_ok)
  );

  typedef struct packed {
    logic            fifo;
    logic [2:0][1:0] ord;   // ord[k] = mailbox loaded k-th
    logic [2:0][10:0] ids;  // ids[m] = identifier of mailbox m
    logic [1:0]      exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, {2'd2, 2'd1, 2'd0}, {11'd9, 11'd3, 11'd5}, 2'd1},       // R3
    '{1'b0, {2'd2, 2'd1, 2'd0}, {11'd2, 11'd7, 11'd7}, 2'd2},       // R3
    '{1'b0, {2'd0, 2'd2, 2'd1}, {11'd6, 11'd4, 11'd4}, 2'd0},       // R4
    '{1'b0, {2'd1, 2'd2, 2'd0}, {11'd1, 11'd1, 11'd8}, 2'd1},       // R4
    '{1'b1, {2'd1, 2'd0, 2'd2}, {11'd3, 11'd2, 11'd1}, 2'd2},       // R5
    '{1'b1, {2'd0, 2'd2, 2'd1}, {11'd0, 11'd5, 11'd0}, 2'd1},       // R5
    '{1'b0, {2'd1, 2'd0, 2'd2}, {11'h7FF, 11'd9, 11'd9}, 2'd0},     // R4
    '{1'b1, {2'd2, 2'd1, 2'd0}, {11'd0, 11'd0, 11'h7FF}, 2'd0}      // R5
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load_mb(input int idx, input int id);
    load_valid = 1'b1; load_idx = 2'(idx); load_id = ID_W'(id);
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic start_att();
    att_start = 1'b1;
    @(negedge clk);
    att_start = 1'b0;
  endtask

  task automatic finish_att(input int res);
    att_done = 1'b1; att_result = 2'(res);
    @(negedge clk);
    att_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check(!sel_valid, "R1 sel_valid", sel_valid, 0);
    check(!done_valid, "R1 done_valid", done_valid, 0);

    // table-driven selection
    for (int v = 0; v < 8; v++) begin
      cfg_fifo_order = VECS[v].fifo;
      do_reset();
      for (int k = 0; k < 3; k++) load_mb(VECS[v].ord[k], VECS[v].ids[VECS[v].ord[k]]);
      check(sel_valid && sel_idx == VECS[v].exp, "R3 R4 R5 sel_idx", sel_idx, VECS[v].exp);
      check(sel_id == VECS[v].ids[VECS[v].exp], "R3 R4 R5 sel_id", sel_id, VECS[v].ids[VECS[v].exp]);
    end

    // R10: idle start and stray done
    cfg_fifo_order = 1'b0; cfg_no_retry = 1'b0;
    do_reset();
    start_att();
    check(!sel_valid, "R10 start with none pending", sel_valid, 0);
    finish_att(0);
    check(!done_valid, "R10 stray done", done_valid, 0);

    // R2: load on pending mailbox ignored
    load_mb(0, 10);
    load_mb(0, 1);
    check(sel_id == 10, "R2 pending load ignored", sel_id, 10);
    load_mb(1, 20);

    // R6: hold during attempt
    start_att();
    load_mb(2, 2);
    check(sel_idx == 0 && sel_id == 10, "R6 held sel_idx", sel_idx, 0);

    // R7: success
    finish_att(0);
    check(done_valid && done_ok && done_idx == 0, "R7 done report", {done_valid, done_ok, done_idx}, 7'b1100);
    check(sel_idx == 2, "R7 next offer", sel_idx, 2);
    load_mb(0, 0);
    check(sel_idx == 0 && sel_id == 0, "R7 mailbox freed", sel_id, 0);

    // R8: failures retried
    start_att();
    finish_att(1);
    check(!done_valid, "R8 arb lost no done", done_valid, 0);
    check(sel_valid && sel_idx == 0, "R8 still offered", sel_idx, 0);
    start_att();
    finish_att(2);
    check(!done_valid && sel_idx == 0, "R8 error retried", sel_idx, 0);

    // R9: no retry
    cfg_no_retry = 1'b1;
    start_att();
    finish_att(1);
    check(done_valid && !done_ok && done_idx == 0, "R9 failure report", {done_valid, done_ok, done_idx}, 7'b1000);
    check(sel_idx == 2, "R9 mailbox freed", sel_idx, 2);
    start_att();
    finish_att(3);
    check(done_valid && !done_ok && done_idx == 2, "R9 code 3 as failure", done_idx, 2);

    // R5: arrival order kept across retirement
    cfg_fifo_order = 1'b1; cfg_no_retry = 1'b0;
    do_reset();
    load_mb(1, 50);
    load_mb(2, 40);
    load_mb(0, 30);
    check(sel_idx == 1, "R5 head", sel_idx, 1);
    start_att();
    finish_att(0);
    check(sel_idx == 2, "R5 after retire", sel_idx, 2);
    load_mb(1, 5);
    cfg_no_retry = 1'b1;
    start_att();
    finish_att(2);
    check(sel_idx == 0, "R5 second head", sel_idx, 0);
    start_att();
    finish_att(0);
    check(sel_valid && sel_idx == 1, "R5 reloaded last", sel_idx, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule